// File: doc/BRIEF.md
# Memory-to-Memory Instruction Sequencer

This block is a small multicycle processor with no accumulator and no register file. Every instruction names its operands by memory address. Instructions and data share one synchronous memory of 1024 words of 36 bits. A program can move words, add or subtract them three-address style, compare two words, and branch. A branch is either unconditional or depends on the condition flags left by the most recent compare.

An instruction word places the 6-bit opcode in bits 35:30. Below it sit three 10-bit address fields: A in bits 29:20, B in bits 19:10 and C in bits 9:0. The opcode values are MOVE=1, ADD=2, SUBTRACT=3, COMPARE=4, JUMP=5 and JUMPGT=6. Opcode 0 halts, and any other opcode halts as illegal. Arithmetic treats the low 16 bits of a word as two's complement. An arithmetic result is stored with bits 35:16 cleared.

The instruction stage sequence is:
- fetch: read the word at the PC into the instruction register, then increment the PC;
- decode;
- read each source operand, one at a time;
- finish with a single write, flag update or branch stage.

While reset is held or after the core has halted, a side port gives access to the memory. A test environment uses it to preload a program, release reset and read back results once halt is raised.

Top module: `mm_seq`

## Requirements
- R1: While reset is asserted, the PC is 0 and halt, illegal and all three flags (GT, EQ, LT) read 0. Execution starts at address 0 after reset is released.
- R2: MOVE (op 1) copies the full 36-bit word at address A into address B and leaves the word at A unchanged.
- R3: ADD (op 2) stores the 16-bit sum of the words at A and B into address C, with bits 35:16 cleared. C may equal A or B.
- R4: SUBTRACT (op 3) stores the 16-bit difference, word at A minus word at B, into address C, with bits 35:16 cleared.
- R5: COMPARE (op 4) compares the signed 16-bit values at A and B. It sets exactly one of GT (A>B), EQ or LT and writes no memory.
- R6: JUMP (op 5) continues execution at address A.
- R7: JUMPGT (op 6) continues at address A when GT is set. Otherwise it continues with the next word.
- R8: The flags change only on COMPARE. MOVE, ADD, SUBTRACT and branches leave them as they were.
- R9: Opcode 0 raises halt and keeps it raised until reset. The PC then rests at the halt word's address plus 1.
- R10: Opcodes 7 to 63 raise both halt and illegal, and the illegal instruction writes no memory.
- R11: Address fields that an opcode does not use have no effect.
- R12: A word written by an instruction is seen by the fetch of the very next instruction when that fetch reads the same address.
- R13: A loop made of COMPARE, JUMPGT, ADD and JUMP that sums 1 to 100 leaves 5050 in its result word and then halts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_we | input | 1 | Side-port write enable, honoured in reset or halt |
| ext_addr | input | 10 | Side-port word address |
| ext_wdata | input | 36 | Side-port write data |
| ext_rdata | output | 36 | Memory word at the previous cycle's side-port address |
| pc | output | 10 | Program counter |
| flag_gt | output | 1 | Last compare found A greater |
| flag_eq | output | 1 | Last compare found equal |
| flag_lt | output | 1 | Last compare found A less |
| halted | output | 1 | Sticky halt |
| illegal | output | 1 | Halt was caused by an undefined opcode |

## Verification
A result write from one instruction and the fetch of the next instruction land on consecutive cycles. When the destination is the next instruction word, these two memory uses touch the same location back to back. The bench provokes this with a MOVE that overwrites its own successor, where the original and replacement words steer to different halt addresses. The halt PC shows which of the two words was fetched. Randomized operands and directed signed edge values are run through ADD, SUBTRACT and COMPARE programs and judged against bench-computed sums, differences and flags.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int OP_W    = 6;
    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 16;
    localparam int WORD_W  = OP_W + 3 * ADDR_W;
    localparam int MEM_DEPTH = 1 << ADDR_W;

    localparam logic [OP_W-1:0] OP_HALT = 6'd0;
    localparam logic [OP_W-1:0] OP_MOVE = 6'd1;
    localparam logic [OP_W-1:0] OP_ADD  = 6'd2;
    localparam logic [OP_W-1:0] OP_SUB  = 6'd3;
    localparam logic [OP_W-1:0] OP_CMP  = 6'd4;
    localparam logic [OP_W-1:0] OP_JMP  = 6'd5;
    localparam logic [OP_W-1:0] OP_JGT  = 6'd6;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] b;
        logic [ADDR_W-1:0] c;
    } instr_t;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } flags_t;

    typedef enum logic [1:0] {
        CL_STOP,
        CL_NOSRC,
        CL_ONESRC,
        CL_TWOSRC
    } op_class_e;

    typedef enum logic [3:0] {
        S_FETCH, S_IR, S_DECODE, S_RDA, S_CAPA, S_RDB, S_CAPB, S_EXEC, S_HALT
    } state_e;

    function automatic op_class_e classify(input logic [OP_W-1:0] op);
        case (op)
            OP_MOVE:                return CL_ONESRC;
            OP_ADD, OP_SUB, OP_CMP: return CL_TWOSRC;
            OP_JMP, OP_JGT:         return CL_NOSRC;
            default:                return CL_STOP;
        endcase
    endfunction

    function automatic logic is_defined(input logic [OP_W-1:0] op);
        return op <= OP_JGT;
    endfunction

    function automatic flags_t compare_words(input logic [DATA_W-1:0] x,
                                             input logic [DATA_W-1:0] y);
        flags_t f;
        f.gt = $signed(x) >  $signed(y);
        f.eq = x == y;
        f.lt = $signed(x) <  $signed(y);
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] arith(input logic [OP_W-1:0] op,
                                                input logic [DATA_W-1:0] x,
                                                input logic [DATA_W-1:0] y);
        logic [DATA_W-1:0] r;
        r = (op == OP_SUB) ? x - y : x + y;
        return {{(WORD_W-DATA_W){1'b0}}, r};
    endfunction
endpackage

// File: rtl/mm_mem.sv
module mm_mem #(
    parameter int AW = mm_pkg::ADDR_W,
    parameter int DW = mm_pkg::WORD_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        rdata <= store[addr];
    end
endmodule

// File: rtl/mm_flags.sv
module mm_flags
    import mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output flags_t            flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (cmp_en) begin
            flags <= compare_words(x, y);
        end
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flags.gt, flags.eq, flags.lt})); // R5
    AST_CMP_SETS_ONE: assert property (@(posedge clk) disable iff (rst)
        cmp_en |=> $countones({flags.gt, flags.eq, flags.lt}) == 1); // R5
    AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (rst)
        !cmp_en |=> $stable(flags)); // R8
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rd_word,
    input  flags_t            flags,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              cmp_en,
    output logic [DATA_W-1:0] cmp_x,
    output logic [DATA_W-1:0] cmp_y,
    output logic [ADDR_W-1:0] pc_o,
    output logic              halted,
    output logic              illegal
);
    state_e            st, st_n;
    logic [ADDR_W-1:0] pc;
    instr_t            ir;
    logic [WORD_W-1:0] opa, opb;
    op_class_e         cls;
    logic              take_branch;

    assign cls         = classify(ir.op);
    assign take_branch = (ir.op == OP_JMP) || (ir.op == OP_JGT && flags.gt);

    always_comb begin
        st_n = st;
        case (st)
            S_FETCH:  st_n = S_IR;
            S_IR:     st_n = S_DECODE;
            S_DECODE: begin
                case (cls)
                    CL_STOP:  st_n = S_HALT;
                    CL_NOSRC: st_n = S_EXEC;
                    default:  st_n = S_RDA;
                endcase
            end
            S_RDA:    st_n = S_CAPA;
            S_CAPA:   st_n = (cls == CL_TWOSRC) ? S_RDB : S_EXEC;
            S_RDB:    st_n = S_CAPB;
            S_CAPB:   st_n = S_EXEC;
            S_EXEC:   st_n = S_FETCH;
            default:  st_n = S_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_FETCH;
            pc      <= '0;
            ir      <= '0;
            opa     <= '0;
            opb     <= '0;
            illegal <= 1'b0;
        end else begin
            st <= st_n;
            case (st)
                S_IR: begin
                    ir <= rd_word;
                    pc <= pc + 1'b1;
                end
                S_DECODE: begin
                    if (!is_defined(ir.op)) begin
                        illegal <= 1'b1;
                    end
                end
                S_CAPA: opa <= rd_word;
                S_CAPB: opb <= rd_word;
                S_EXEC: begin
                    if (take_branch) begin
                        pc <= ir.a;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = arith(ir.op, opa[DATA_W-1:0], opb[DATA_W-1:0]);
        case (st)
            S_RDA: mem_addr = ir.a;
            S_RDB: mem_addr = ir.b;
            S_EXEC: begin
                if (ir.op == OP_MOVE) begin
                    mem_addr  = ir.b;
                    mem_we    = 1'b1;
                    mem_wdata = opa;
                end else if (ir.op == OP_ADD || ir.op == OP_SUB) begin
                    mem_addr = ir.c;
                    mem_we   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign cmp_en = (st == S_EXEC) && (ir.op == OP_CMP);
    assign cmp_x  = opa[DATA_W-1:0];
    assign cmp_y  = opb[DATA_W-1:0];
    assign pc_o   = pc;
    assign halted = (st == S_HALT);

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R9
    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc_o)); // R9
    AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we); // R10
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (st == S_EXEC && ir.op == OP_JMP) |=> pc_o == $past(ir.a)); // R6
    AST_JGT_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (st == S_EXEC && ir.op == OP_JGT && !flags.gt) |=> $stable(pc_o)); // R7
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        cmp_en |-> !mem_we); // R5
endmodule

// File: rtl/mm_seq.sv
module mm_seq
    import mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [WORD_W-1:0] ext_wdata,
    output logic [WORD_W-1:0] ext_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic              flag_gt,
    output logic              flag_eq,
    output logic              flag_lt,
    output logic              halted,
    output logic              illegal
);
    logic [ADDR_W-1:0] core_addr, m_addr;
    logic [WORD_W-1:0] core_wdata, m_wdata, m_rdata;
    logic              core_we, m_we, core_active, cmp_en;
    logic [DATA_W-1:0] cmp_x, cmp_y;
    flags_t            flags;

    assign core_active = !rst && !halted;
    assign m_addr      = core_active ? core_addr  : ext_addr;
    assign m_we        = core_active ? core_we    : ext_we;
    assign m_wdata     = core_active ? core_wdata : ext_wdata;
    assign ext_rdata   = m_rdata;

    mm_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
        .clk   (clk),
        .we    (m_we),
        .addr  (m_addr),
        .wdata (m_wdata),
        .rdata (m_rdata)
    );

    mm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rd_word   (m_rdata),
        .flags     (flags),
        .mem_addr  (core_addr),
        .mem_we    (core_we),
        .mem_wdata (core_wdata),
        .cmp_en    (cmp_en),
        .cmp_x     (cmp_x),
        .cmp_y     (cmp_y),
        .pc_o      (pc),
        .halted    (halted),
        .illegal   (illegal)
    );

    mm_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .cmp_en (cmp_en),
        .x      (cmp_x),
        .y      (cmp_y),
        .flags  (flags)
    );

    assign flag_gt = flags.gt;
    assign flag_eq = flags.eq;
    assign flag_lt = flags.lt;

    AST_ILLEGAL_IMPLIES_HALT: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted); // R10
endmodule

// File: tb/test_mm_seq.sv
`timescale 1ns/1ps
module test_mm_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_we = 1'b0;
    logic [9:0]  ext_addr = '0;
    logic [35:0] ext_wdata = '0;
    logic [35:0] ext_rdata;
    logic [9:0]  pc;
    logic        flag_gt, flag_eq, flag_lt, halted, illegal;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    mm_seq i_mm_seq (
        .clk(clk), .rst(rst), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .pc(pc),
        .flag_gt(flag_gt), .flag_eq(flag_eq), .flag_lt(flag_lt),
        .halted(halted), .illegal(illegal)
    );

    function automatic logic [35:0] ins(input int op, input int a, input int b, input int c);
        return {op[5:0], a[9:0], b[9:0], c[9:0]};
    endfunction

    function automatic logic [35:0] dword(input logic [15:0] v);
        return {20'b0, v};
    endfunction

    function automatic logic [2:0] exp_flags(input logic [15:0] x, input logic [15:0] y);
        int sx, sy;
        sx = $signed(x);
        sy = $signed(y);
        return {sx > sy, sx == sy, sx < sy};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [35:0] d);
        @(negedge clk);
        ext_we = 1'b1; ext_addr = a[9:0]; ext_wdata = d;
        @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic peek(input int a, output logic [35:0] d);
        @(negedge clk);
        ext_addr = a[9:0];
        @(negedge clk);
        d = ext_rdata;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic run(input string req);
        bit done = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 30000 && !done; i++) begin
            @(negedge clk);
            if (halted) done = 1'b1;
        end
        chk(done, {req, " watchdog"}, 36'(halted), 36'd1);
    endtask

    task automatic expect_word(input int a, input logic [35:0] exp, input string req);
        logic [35:0] v;
        peek(a, v);
        chk(v === exp, req, v, exp);
    endtask

    initial begin
        #(8 * 190000);
        miscompares++;
        $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [35:0] v;
        logic [15:0] x, y;
        logic [2:0]  ef;
        int          seed = 32'h5eed;
        int          sum;
        v = $urandom(seed);

        // R1 reset state
        hold_reset();
        repeat (3) @(negedge clk);
        chk(pc == 0 && !halted && !illegal, "R1 pc/halt", {pc, halted, illegal}, '0);
        chk({flag_gt, flag_eq, flag_lt} == 3'b000, "R1 flags", 36'({flag_gt, flag_eq, flag_lt}), '0);

        // R2 MOVE, R9 halt pc
        x = 16'($urandom);
        poke(100, {20'hABCDE, x});
        poke(101, '0);
        poke(0, ins(1, 100, 101, 0));
        poke(1, ins(0, 0, 0, 0));
        run("R2");
        expect_word(101, {20'hABCDE, x}, "R2 dest");
        expect_word(100, {20'hABCDE, x}, "R2 src kept");
        chk(pc == 2, "R9 halt pc", 36'(pc), 36'd2);
        repeat (5) @(negedge clk);
        chk(halted && pc == 2, "R9 sticky", {pc, halted}, {10'd2, 1'b1});

        // R3 R4 R5: random and directed operands
        for (int k = 0; k < 24; k++) begin
            case (k)
                0: begin x = 16'h7FFF; y = 16'h8000; end
                1: begin x = 16'h8000; y = 16'h7FFF; end
                2: begin x = 16'h1234; y = 16'h1234; end
                3: begin x = 16'hFFFF; y = 16'h0001; end
                default: begin x = 16'($urandom); y = 16'($urandom); end
            endcase
            hold_reset();
            poke(100, dword(x));
            poke(101, dword(y));
            poke(102, 36'hFFFFFFFFF);
            poke(103, 36'hFFFFFFFFF);
            poke(0, ins(2, 100, 101, 102));
            poke(1, ins(3, 100, 101, 103));
            poke(2, ins(4, 100, 101, 0));
            poke(3, ins(0, 0, 0, 0));
            run("R3");
            expect_word(102, dword(x + y), "R3 sum");
            expect_word(103, dword(x - y), "R4 difference");
            ef = exp_flags(x, y);
            chk({flag_gt, flag_eq, flag_lt} == ef, "R5 flags",
                36'({flag_gt, flag_eq, flag_lt}), 36'(ef));
            expect_word(100, dword(x), "R5 no write");
            expect_word(101, dword(y), "R5 no write");
        end

        // R3 aliasing C=A
        hold_reset();
        poke(100, dword(16'd300));
        poke(101, dword(16'd45));
        poke(0, ins(2, 100, 101, 100));
        poke(1, ins(0, 0, 0, 0));
        run("R3");
        expect_word(100, dword(16'd345), "R3 alias");

        // R8 flags survive MOVE/ADD/SUB/JUMP
        hold_reset();
        poke(100, dword(16'd9));
        poke(101, dword(16'd2));
        poke(0, ins(4, 100, 101, 0));
        poke(1, ins(1, 101, 100, 0));
        poke(2, ins(2, 100, 101, 102));
        poke(3, ins(3, 101, 100, 103));
        poke(4, ins(5, 5, 0, 0));
        poke(5, ins(0, 0, 0, 0));
        run("R8");
        chk({flag_gt, flag_eq, flag_lt} == 3'b100, "R8 flags kept",
            36'({flag_gt, flag_eq, flag_lt}), 36'b100);

        // R7 JUMPGT taken and not taken
        for (int t = 0; t < 2; t++) begin
            hold_reset();
            poke(100, dword(t == 0 ? 16'd50 : 16'd5));
            poke(101, dword(16'd20));
            poke(110, dword(16'd7));
            poke(111, '0);
            poke(112, dword(16'd8));
            poke(113, '0);
            poke(0, ins(4, 100, 101, 0));
            poke(1, ins(6, 5, 0, 0));
            poke(2, ins(1, 110, 111, 0));
            poke(3, ins(0, 0, 0, 0));
            poke(5, ins(1, 112, 113, 0));
            poke(6, ins(0, 0, 0, 0));
            run("R7");
            if (t == 0) begin
                chk(pc == 7, "R7 taken pc", 36'(pc), 36'd7);
                expect_word(113, dword(16'd8), "R7 taken path");
                expect_word(111, '0, "R7 skipped path");
            end else begin
                chk(pc == 4, "R7 fallthrough pc", 36'(pc), 36'd4);
                expect_word(111, dword(16'd7), "R7 fallthrough path");
                expect_word(113, '0, "R7 skipped path");
            end
        end

        // R6 JUMP skips words; R11 garbage in unused fields
        hold_reset();
        poke(110, dword(16'd7));
        poke(111, '0);
        poke(0, ins(5, 3, 111, 110));
        poke(1, ins(1, 110, 111, 0));
        poke(2, ins(1, 110, 111, 0));
        poke(3, ins(0, 0, 0, 0));
        run("R6");
        chk(pc == 4, "R6 jump pc", 36'(pc), 36'd4);
        expect_word(111, '0, "R6 skipped words");

        // R11 MOVE and COMPARE with live C field
        hold_reset();
        poke(100, dword(16'd1));
        poke(101, dword(16'd1));
        poke(120, dword(16'h5A5A));
        poke(0, ins(1, 100, 101, 120));
        poke(1, ins(4, 100, 101, 120));
        poke(2, ins(0, 120, 120, 120));
        run("R11");
        expect_word(120, dword(16'h5A5A), "R11 unused C");
        chk({flag_gt, flag_eq, flag_lt} == 3'b010, "R11 compare",
            36'({flag_gt, flag_eq, flag_lt}), 36'b010);
        chk(pc == 3 && !illegal, "R11 halt fields", {pc, illegal}, {10'd3, 1'b0});

        // R10 illegal opcodes
        for (int t = 0; t < 2; t++) begin
            hold_reset();
            poke(120, dword(16'h1111));
            poke(0, ins(t == 0 ? 7 : 63, 120, 120, 120));
            poke(1, ins(0, 0, 0, 0));
            run("R10");
            chk(halted && illegal && pc == 1, "R10 illegal halt",
                {pc, halted, illegal}, {10'd1, 1'b1, 1'b1});
            expect_word(120, dword(16'h1111), "R10 no write");
        end

        // R12 write then fetch of the same word
        hold_reset();
        poke(50, ins(0, 0, 0, 0));
        poke(0, ins(1, 50, 1, 0));
        poke(1, ins(5, 40, 0, 0));
        poke(40, ins(0, 0, 0, 0));
        run("R12");
        chk(pc == 2, "R12 fetched new word", 36'(pc), 36'd2);

        // R13 summation loop
        hold_reset();
        poke(200, dword(16'd0));
        poke(201, dword(16'd1));
        poke(202, dword(16'd100));
        poke(205, '0);
        poke(0, ins(1, 200, 203, 0));
        poke(1, ins(1, 201, 204, 0));
        poke(2, ins(4, 204, 202, 0));
        poke(3, ins(6, 7, 0, 0));
        poke(4, ins(2, 203, 204, 203));
        poke(5, ins(2, 204, 201, 204));
        poke(6, ins(5, 2, 0, 0));
        poke(7, ins(1, 203, 205, 0));
        poke(8, ins(0, 0, 0, 0));
        run("R13");
        sum = 0;
        for (int i = 1; i <= 100; i++) sum += i;
        expect_word(205, dword(16'(sum)), "R13 result");
        chk(halted && pc == 9, "R13 halt", {pc, halted}, {10'd9, 1'b1});

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule